// File: doc/BRIEF.md
# Staged PWM Timer with Power-of-Two Prescaler

This block produces a single active-high pulse-width-modulated output from two memory-mapped registers. A control word holds the run enable, a staging flag and a five-bit prescale exponent n. That exponent is split across a four-bit select field and a separate low-order bit. A count word holds a 10-bit period length and a 10-bit high-time length, both counted in prescaled ticks. The prescaled tick runs at the input clock rate divided by 2^n. The output is high for the first part of every period and low for the rest. The hardware cannot produce a 0% duty cycle.

The programmed fields are shadow copies. The waveform generator runs from a separate active copy. While the staging flag is clear, the active copy reloads from the shadows at every period boundary. It also reloads on every cycle while the channel is idle. Software sets the staging flag, rewrites the period, high time and exponent, then clears the flag. The whole new setting then takes effect together at the next period boundary. A period or high time of zero is prohibited. Either one keeps the channel idle with the output low.

Top module: `stagepwm_top`

## Requirements
- R1: After a synchronous reset both registers read as zero and `pwm_out` is low.
- R2: Control word at byte offset 0x00: bit 0 run enable, bit 4 a spare read/write flag with no effect on the output, bit 11 staging flag, bit 15 exponent bit n[0], bits 19:16 exponent bits n[4:1]. Count word at offset 0x04: period in bits 25:16, high time in bits 9:0. All other bit positions read as zero. Any other offset reads as zero, and writes to it change nothing.
- R3: The tick that drives the period counter occurs once every 2^n input clock cycles. An exponent above 24 behaves as 24.
- R4: When running with period P and high time H < P, every period lasts exactly P·2^n clock cycles, and `pwm_out` is high for exactly the first H·2^n of them.
- R5: When running with H ≥ P, `pwm_out` stays high continuously.
- R6: If the active period or high time is zero, the counters are held at zero and `pwm_out` is low. A later legal count word, written while the staging flag is clear, starts the channel.
- R7: Clearing the run enable drives `pwm_out` low on the second clock edge after the write, at the latest, and keeps it low.
- R8: While the staging flag is set, the active period, high time and exponent do not change. Reads still return the newly written values.
- R9: After the staging flag is cleared, the new period, high time and exponent take effect together at the next period boundary.
- R10: A read request returns its data on `bus_rdata`, with `bus_rvalid` high, one clock cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pwm_out | output | 1 | PWM output, active high |

## Verification
A wrong active setting or a stray reload shows at the port as a period length or a high time that is off by a multiple of 2^n cycles. Such an error appears within the first full period after the change. The bench therefore measures the cycles between successive rising edges, and the high cycles between them. A staging flag that leaks lets the new timing appear in the period right after the write, rather than after the flag is cleared. A missing idle hold shows as a pulse while the count word holds a zero, or within two cycles after the enable is cleared. Register decode faults appear on the next read-back.

// File: rtl/stagepwm_pkg.sv
package stagepwm_pkg;

  localparam int DATA_W  = 32;
  localparam int CNT_W   = 10;
  localparam int EXP_W   = 5;
  localparam int EXP_MAX = 24;

  // register offsets (bytes)
  localparam int OFS_CTRL = 0;
  localparam int OFS_CNT  = 4;

  // control word bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_SPARE = 4;
  localparam int BIT_STAGE = 11;
  localparam int BIT_XLSB  = 15;
  localparam int SEL_LO    = 16;

  // count word field positions
  localparam int PER_LO = 16;
  localparam int HI_LO  = 0;

  typedef struct packed {
    logic [EXP_W-1:0] expo;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] hightime;
  } pwm_cfg_t;

endpackage

// File: rtl/stagepwm_regs.sv
module stagepwm_regs
  import stagepwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              run_en,
  output logic              stage,
  output pwm_cfg_t          shadow
);

  logic             en_q, spare_q, stage_q;
  logic [EXP_W-1:0] expo_q;
  logic [CNT_W-1:0] per_q, hi_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic             rvalid_q;
  logic             sel_ctrl, sel_cnt, wr_go, rd_go;
  logic             unused_wdata;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
  assign wr_go    = bus_valid && bus_write;
  assign rd_go    = bus_valid && !bus_write;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[BIT_EN]    = en_q;
      rd_mux[BIT_SPARE] = spare_q;
      rd_mux[BIT_STAGE] = stage_q;
      rd_mux[BIT_XLSB]  = expo_q[0];
      rd_mux[SEL_LO +: EXP_W-1] = expo_q[EXP_W-1:1];
    end else if (sel_cnt) begin
      rd_mux[PER_LO +: CNT_W] = per_q;
      rd_mux[HI_LO  +: CNT_W] = hi_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      spare_q  <= 1'b0;
      stage_q  <= 1'b0;
      expo_q   <= '0;
      per_q    <= '0;
      hi_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_go;
      if (rd_go) rdata_q <= rd_mux;
      if (wr_go && sel_ctrl) begin
        en_q    <= bus_wdata[BIT_EN];
        spare_q <= bus_wdata[BIT_SPARE];
        stage_q <= bus_wdata[BIT_STAGE];
        expo_q  <= {bus_wdata[SEL_LO +: EXP_W-1], bus_wdata[BIT_XLSB]};
      end
      if (wr_go && sel_cnt) begin
        per_q <= bus_wdata[PER_LO +: CNT_W];
        hi_q  <= bus_wdata[HI_LO +: CNT_W];
      end
    end
  end

  assign bus_rdata       = rdata_q;
  assign bus_rvalid      = rvalid_q;
  assign run_en          = en_q;
  assign stage           = stage_q;
  assign shadow.expo     = expo_q;
  assign shadow.period   = per_q;
  assign shadow.hightime = hi_q;

endmodule

// File: rtl/stagepwm_prescale.sv
module stagepwm_prescale #(
  parameter int EXP_W   = 5,
  parameter int EXP_MAX = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);

  generate
    if (EXP_MAX == 0) begin : g_nodiv
      logic unused_in;
      assign unused_in = ^{clear, expo};
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = EXP_MAX;
      logic [CW-1:0] cnt_q;
      logic [EXP_W-1:0] expo_eff;
      logic [CW:0]   full;
      logic [CW-1:0] mask;

      assign expo_eff = (expo > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : expo;
      assign full = ({{CW{1'b0}}, 1'b1} << expo_eff) - {{CW{1'b0}}, 1'b1};
      assign mask = full[CW-1:0];
      assign tick = ((cnt_q & mask) == mask);

      always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else              cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
      end
    end
  endgenerate

endmodule

// File: rtl/stagepwm_core.sv
module stagepwm_core
  import stagepwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             stage,
  input  pwm_cfg_t         shadow,
  input  logic             tick,
  output logic             presc_clr,
  output pwm_cfg_t         active,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             pwm_out
);

  pwm_cfg_t         act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             out_q;
  logic             run, wrap, load;

  assign run  = run_en && (act_q.period != '0) && (act_q.hightime != '0);
  assign wrap = run && tick &&
                (cnt_q == act_q.period - {{(CNT_W-1){1'b0}}, 1'b1});
  assign load = !stage && (!run || wrap);
  assign presc_clr = !run || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (load) act_q <= shadow;
      if (!run || wrap) cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      out_q <= run && (cnt_q < act_q.hightime);
    end
  end

  assign active  = act_q;
  assign count   = cnt_q;
  assign running = run;
  assign pwm_out = out_q;

endmodule

// File: rtl/stagepwm_top.sv
module stagepwm_top
  import stagepwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              pwm_out
);

  logic             ctl_en, ctl_stage, tick, presc_clr, core_run;
  pwm_cfg_t         shadow_cfg, active_cfg;
  logic [CNT_W-1:0] core_cnt;

  stagepwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .run_en(ctl_en), .stage(ctl_stage), .shadow(shadow_cfg)
  );

  stagepwm_prescale #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_presc (
    .clk(clk), .rst(rst), .clear(presc_clr), .expo(active_cfg.expo), .tick(tick)
  );

  stagepwm_core u_core (
    .clk(clk), .rst(rst), .run_en(ctl_en), .stage(ctl_stage),
    .shadow(shadow_cfg), .tick(tick), .presc_clr(presc_clr),
    .active(active_cfg), .count(core_cnt), .running(core_run),
    .pwm_out(pwm_out)
  );

endmodule

// File: rtl/stagepwm_checker.sv
module stagepwm_checker
  import stagepwm_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [31:0]      bus_rdata,
  input logic             bus_rvalid,
  input logic             pwm_out,
  input logic             ctl_en,
  input logic             ctl_stage,
  input pwm_cfg_t         active_cfg,
  input logic [CNT_W-1:0] core_cnt,
  input logic             core_run
);

  localparam logic [31:0] USED = 32'h03FF_8BFF;

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> ((bus_rdata & ~USED) == 32'h0));

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    core_run |-> (core_cnt < active_cfg.period));

  p_high_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (core_run && core_cnt < active_cfg.hightime) |=> pwm_out);

  p_low_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (core_run && core_cnt >= active_cfg.hightime) |=> !pwm_out);

  p_zero_low_r6: assert property (@(posedge clk) disable iff (rst)
    (active_cfg.period == '0 || active_cfg.hightime == '0) |=> !pwm_out);

  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> !pwm_out);

  p_stage_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_stage |=> $stable(active_cfg));

  p_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);

endmodule

bind stagepwm_top stagepwm_checker u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pwm_out(pwm_out),
  .ctl_en(ctl_en), .ctl_stage(ctl_stage), .active_cfg(active_cfg),
  .core_cnt(core_cnt), .core_run(core_run)
);

// File: tb/stagepwm_top_bench.sv
module stagepwm_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  stagepwm_top u_stagepwm_top (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pwm_out(pwm_out)
  );

  // vector: {exponent[4:0], period[9:0], hightime[9:0]}
  localparam int NV = 7;
  localparam logic [24:0] VEC [NV] = '{
    {5'd0, 10'd10, 10'd3},
    {5'd0, 10'd7,  10'd1},
    {5'd1, 10'd5,  10'd2},
    {5'd2, 10'd6,  10'd5},
    {5'd3, 10'd4,  10'd1},
    {5'd0, 10'd2,  10'd1},
    {5'd1, 10'd9,  10'd8}
  };

  function automatic logic [31:0] ctrl_word(bit en, bit stg, logic [4:0] e);
    return (32'(en)) | (32'(stg) << 11) | (32'(e[0]) << 15) | (32'(e[4:1]) << 16);
  endfunction

  function automatic logic [31:0] cnt_word(int p, int h);
    return (32'(p) << 16) | 32'(h);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic wait_rise(output bit ok);
    logic prev;
    prev = pwm_out; ok = 1'b0;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (pwm_out && !prev) begin ok = 1'b1; return; end
      prev = pwm_out;
    end
  endtask

  task automatic measure(output int hi, output int tot);
    bit ok;
    logic prev;
    hi = -1; tot = -1;
    wait_rise(ok);
    if (!ok) return;
    wait_rise(ok);
    if (!ok) return;
    hi = 1; tot = 1; prev = 1'b1;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (pwm_out && !prev) return;
      tot++;
      if (pwm_out) hi++;
      prev = pwm_out;
    end
  endtask

  task automatic count_high(int n, output int hi);
    hi = 0;
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    logic [31:0] d;
    logic v;
    int hi, tot, e, p, h;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(pwm_out == 1'b0, "R1 pwm_out after reset", int'(pwm_out), 0);
    rd(4'h0, d, v);
    check(d == 32'h0, "R1 control after reset", int'(d), 0);
    check(v == 1'b1, "R10 rvalid on read", int'(v), 1);
    rd(4'h4, d, v);
    check(d == 32'h0, "R1 count after reset", int'(d), 0);

    // R2 field positions and unused bits
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d, v);
    check(d == 32'h000F_8811, "R2 control readback", int'(d), 32'h000F_8811);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d, v);
    check(d == 32'h03FF_03FF, "R2 count readback", int'(d), 32'h03FF_03FF);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d, v);
    check(d == 32'h0, "R2 unmapped offset reads zero", int'(d), 0);
    rd(4'h0, d, v);
    check(d == 32'h000F_8811, "R2 unmapped write ignored", int'(d), 32'h000F_8811);
    wr(4'h0, 32'h0);

    // R3 / R4 vector walk
    for (int i = 0; i < NV; i++) begin
      e = int'(VEC[i][24:20]); p = int'(VEC[i][19:10]); h = int'(VEC[i][9:0]);
      wr(4'h0, 32'h0);
      wr(4'h4, cnt_word(p, h));
      wr(4'h0, ctrl_word(1'b1, 1'b0, 5'(e)));
      measure(hi, tot);
      check(tot == (p << e), "R3 period length", tot, p << e);
      check(hi == (h << e), "R4 high time", hi, h << e);
    end

    // R5 hightime >= period
    wr(4'h0, 32'h0);
    wr(4'h4, cnt_word(5, 7));
    wr(4'h0, ctrl_word(1'b1, 1'b0, 5'd0));
    repeat (3) @(negedge clk);
    count_high(40, hi);
    check(hi == 40, "R5 high time above period", hi, 40);
    wr(4'h0, 32'h0);
    wr(4'h4, cnt_word(4, 4));
    wr(4'h0, ctrl_word(1'b1, 1'b0, 5'd1));
    repeat (3) @(negedge clk);
    count_high(40, hi);
    check(hi == 40, "R5 high time equal period", hi, 40);

    // R6 prohibited zero settings
    wr(4'h0, 32'h0);
    wr(4'h4, cnt_word(8, 0));
    wr(4'h0, ctrl_word(1'b1, 1'b0, 5'd0));
    count_high(40, hi);
    check(hi == 0, "R6 zero high time keeps output low", hi, 0);
    wr(4'h4, cnt_word(0, 5));
    count_high(40, hi);
    check(hi == 0, "R6 zero period keeps output low", hi, 0);
    wr(4'h4, cnt_word(8, 2));
    measure(hi, tot);
    check(tot == 8, "R6 recovery period", tot, 8);
    check(hi == 2, "R6 recovery high time", hi, 2);

    // R7 disable
    wr(4'h0, 32'h0);
    @(negedge clk);
    count_high(30, hi);
    check(hi == 0, "R7 disabled output low", hi, 0);

    // R8 / R9 staged update
    wr(4'h4, cnt_word(10, 3));
    wr(4'h0, ctrl_word(1'b1, 1'b0, 5'd0));
    measure(hi, tot);
    wr(4'h0, ctrl_word(1'b1, 1'b1, 5'd0));
    wr(4'h4, cnt_word(20, 15));
    wr(4'h0, ctrl_word(1'b1, 1'b1, 5'd1));
    measure(hi, tot);
    check(tot == 10, "R8 period held while staging", tot, 10);
    check(hi == 3, "R8 high time held while staging", hi, 3);
    rd(4'h4, d, v);
    check(d == cnt_word(20, 15), "R8 readback of staged count", int'(d), int'(cnt_word(20, 15)));
    rd(4'h0, d, v);
    check(d == ctrl_word(1'b1, 1'b1, 5'd1), "R8 readback of staged control",
          int'(d), int'(ctrl_word(1'b1, 1'b1, 5'd1)));
    wr(4'h0, ctrl_word(1'b1, 1'b0, 5'd1));
    measure(hi, tot);
    check(tot == 40, "R9 new period and exponent applied", tot, 40);
    check(hi == 30, "R9 new high time applied", hi, 30);

    wr(4'h0, 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule